// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block takes in 8-bit frames from a serial data line that is sampled by a shift clock. The block has no start bits, stop bits or parity. The shift clock can arrive from an external partner on `sck_in`. In that case it is brought into the system clock domain through a synchronizer chain and an edge detector. The block can instead drive the shift clock itself on `sck_out`, at a fixed rate set by a parameter. Each rising shift-clock edge captures one data bit, least-significant bit first, into a shift register. When the eighth bit arrives, the byte is moved to a data register and a full flag is raised.

Software uses a small register window with a write strobe and an address. Through it, software enables reception, chooses the clock source, enables the interrupts, reads the received byte and clears the flags by writing ones. A level receive interrupt signals a waiting byte. If a second frame completes before software has cleared the full flag, the new byte is dropped and the earlier byte stays readable. An overrun flag is then raised, and a separate error interrupt replaces the receive interrupt. The overrun flag holds until software clears it. While it is set, completed frames are dropped.

Top module: `sync_rx`

## Requirements
- R1: After reset, all three registers read 0, both interrupts are low, `sck_out` is high and `sck_oe` is low.
- R2: When the external clock is selected (control bit 2 = 1), the data line is sampled on each rising edge of `sck_in`. Eight samples form a byte, with the first sample in bit 0. If the full flag and the overrun flag are both clear, the byte goes to the data register (address 2) and the full flag (status bit 0, address 1) becomes 1.
- R3: `irq_rx` is high exactly while the interrupt enable (control bit 1) is 1, the full flag is 1 and the overrun flag is 0.
- R4: If a frame completes while the full flag is 1, the overrun flag (status bit 1) becomes 1, the full flag stays 1 and the data register keeps its earlier byte.
- R5: `irq_err` is high while the interrupt enable is 1 and the overrun flag is 1. `irq_rx` and `irq_err` are never high together.
- R6: The overrun flag stays set until status bit 1 is written with 1. While it is set, completed frames neither load the data register nor set the full flag, even after the full flag has been cleared.
- R7: If the byte is read and the full flag is cleared by writing 1 to status bit 0 before the next frame completes, consecutive frames are all received and no overrun occurs.
- R8: Writing control bit 0 (receive enable) to 0 drops any partly received frame, so the next frame starts again at bit 0. The data register and both flags are left unchanged.
- R9: When the internal clock is selected (control bit 2 = 0) and reception is enabled, `sck_oe` is 1. `sck_out` idles high and toggles every HALF_DIV system clocks, giving a period of 2*HALF_DIV, and bits are sampled on its rising edges. While reception is disabled or the external clock is selected, `sck_out` stays high.
- R10: Address 0 reads back control bits [2:0] with the upper bits 0. Address 3 reads 0. Writes to address 2 or address 3 have no effect.
- R11: With the interrupt enable at 0, the flags still follow R2 and R4, but both interrupt outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | External shift clock, asynchronous to `clk` |
| sck_out | output | 1 | Generated shift clock, idle high |
| sck_oe | output | 1 | Output enable for `sck_out` |
| rxd | input | 1 | Serial data line |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data, 3 unused |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr`, combinational |
| irq_rx | output | 1 | Receive interrupt, level |
| irq_err | output | 1 | Overrun error interrupt, level |

## Verification
The checker watches every cycle how a completed frame relates to the two flags and the interrupts. It checks that a frame landing on an empty register sets the full flag and raises the receive interrupt when enabled. It checks that a frame landing on a full register sets the overrun flag without dropping the full flag, and that the overrun flag is sticky. It also checks that the two interrupts never overlap, that a disabled receiver never completes a frame, and that the shift clock output stays idle in external-clock mode. Some properties need the whole sequence of bits and register accesses, so only the bench scenarios can show them. These are the bit order and the actual byte values, whether the earlier byte survives an overrun, the restart at bit 0 after a disable, the generated clock period, and the read-back of the register map.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_DATA = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    // bit positions inside the control and status words
    localparam int CTRL_EN  = 0;
    localparam int CTRL_IE  = 1;
    localparam int CTRL_EXT = 2;
    localparam int STAT_FULL = 0;
    localparam int STAT_OVR  = 1;

    typedef struct packed {
        logic ext;
        logic ie;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/srx_clk_front.sv
// Shift-clock front end: synchronizes the external clock and data,
// or generates a fixed-rate clock, and emits one sample strobe per
// rising shift-clock edge.
module srx_clk_front #(
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ext,
    input  logic sck_in,
    input  logic rxd,
    output logic sample,
    output logic bit_val,
    output logic sck_out,
    output logic sck_oe
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [SYNC_STAGES:0]   sck_sh;
        logic [SYNC_STAGES-1:0] rxd_sh;
        logic [DIV_W-1:0]       div;
        logic                   gen_clk;
    } front_t;

    front_t q, d;
    logic ext_rise;
    logic int_rise;

    always_comb begin
        d        = q;
        int_rise = 1'b0;

        d.sck_sh = {q.sck_sh[SYNC_STAGES-1:0], sck_in};
        d.rxd_sh = {q.rxd_sh[SYNC_STAGES-2:0], rxd};
        ext_rise = q.sck_sh[SYNC_STAGES-1] & ~q.sck_sh[SYNC_STAGES];

        if (!en || ext) begin
            d.div     = '0;
            d.gen_clk = 1'b1;
        end else if (q.div == DIV_LAST) begin
            d.div     = '0;
            d.gen_clk = ~q.gen_clk;
            int_rise  = ~q.gen_clk;
        end else begin
            d.div = q.div + 1'b1;
        end

        sample  = en & (ext ? ext_rise : int_rise);
        bit_val = q.rxd_sh[SYNC_STAGES-1];
        sck_out = q.gen_clk;
        sck_oe  = en & ~ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sck_sh  <= '1;
            q.rxd_sh  <= '0;
            q.div     <= '0;
            q.gen_clk <= 1'b1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/srx_shifter.sv
// Bit counter and LSB-first shift register; pulses frame_done for one
// cycle with the assembled word when the last bit is captured.
module srx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sample,
    input  logic              bit_val,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_data
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic [DATA_W-1:0] word;
    } shift_t;

    shift_t q, d;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {bit_val, q.sr[DATA_W-1:1]};

        if (!en) begin
            d.sr  = '0;
            d.cnt = '0;
        end else if (sample) begin
            d.sr = shifted;
            if (q.cnt == CNT_LAST) begin
                d.cnt  = '0;
                d.done = 1'b1;
                d.word = shifted;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        frame_done = q.done;
        frame_data = q.word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/srx_regs.sv
// Control register, data register and the full/overrun flags.
module srx_regs
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic              full_flag,
    output logic              ovr_flag
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic              full;
        logic              ovr;
        logic [DATA_W-1:0] rdr;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;

        if (wr_en) begin
            case (reg_addr_e'(addr))
                A_CTRL: begin
                    d.ctrl.en  = wdata[CTRL_EN];
                    d.ctrl.ie  = wdata[CTRL_IE];
                    d.ctrl.ext = wdata[CTRL_EXT];
                end
                A_STAT: begin
                    if (wdata[STAT_FULL]) d.full = 1'b0;
                    if (wdata[STAT_OVR])  d.ovr  = 1'b0;
                end
                default: ;
            endcase
        end

        // a completing frame is judged on the flags before this cycle's
        // write, and its effect overrides a same-cycle clear
        if (frame_done) begin
            if (q.full) begin
                d.ovr = 1'b1;
            end else if (!q.ovr) begin
                d.rdr  = frame_data;
                d.full = 1'b1;
            end
        end

        rdata = '0;
        case (reg_addr_e'(addr))
            A_CTRL: begin
                rdata[CTRL_EN]  = q.ctrl.en;
                rdata[CTRL_IE]  = q.ctrl.ie;
                rdata[CTRL_EXT] = q.ctrl.ext;
            end
            A_STAT: begin
                rdata[STAT_FULL] = q.full;
                rdata[STAT_OVR]  = q.ovr;
            end
            A_DATA:  rdata = q.rdr;
            default: rdata = '0;
        endcase

        ctrl      = q.ctrl;
        full_flag = q.full;
        ovr_flag  = q.ovr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/sync_rx.sv
module sync_rx
    import srx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              rxd,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_rx,
    output logic              irq_err
);

    ctrl_t             ctrl;
    logic              sample;
    logic              bit_val;
    logic              frame_done;
    logic [DATA_W-1:0] frame_data;
    logic              full_flag;
    logic              ovr_flag;

    srx_clk_front #(
        .HALF_DIV   (HALF_DIV),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctrl.en),
        .ext    (ctrl.ext),
        .sck_in (sck_in),
        .rxd    (rxd),
        .sample (sample),
        .bit_val(bit_val),
        .sck_out(sck_out),
        .sck_oe (sck_oe)
    );

    srx_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl.en),
        .sample    (sample),
        .bit_val   (bit_val),
        .frame_done(frame_done),
        .frame_data(frame_data)
    );

    srx_regs #(
        .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .frame_done(frame_done),
        .frame_data(frame_data),
        .rdata     (rdata),
        .ctrl      (ctrl),
        .full_flag (full_flag),
        .ovr_flag  (ovr_flag)
    );

    // error request replaces the receive request during an overrun
    always_comb begin
        irq_err = ctrl.ie & ovr_flag;
        irq_rx  = ctrl.ie & full_flag & ~ovr_flag;
    end

endmodule

// File: rtl/srx_checker.sv
module srx_checker
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_done,
    input logic              full,
    input logic              ovr,
    input logic              ie,
    input logic              en,
    input logic              ext,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq_rx,
    input logic              irq_err,
    input logic              sck_out,
    input logic              sck_oe
);

    logic clr_full;
    logic clr_ovr;
    assign clr_full = wr_en && (addr == A_STAT) && wdata[STAT_FULL];
    assign clr_ovr  = wr_en && (addr == A_STAT) && wdata[STAT_OVR];

    p_transfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !full && !ovr |=> full);

    p_rx_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !full && !ovr && ie && !(wr_en && addr == A_CTRL) |=> irq_rx);

    p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && full && !clr_full |=> ovr && full);

    p_irq_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_rx && irq_err));

    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && !clr_ovr |=> ovr);

    p_ovr_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !full && ovr |=> !full);

    p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !frame_done);

    p_ext_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext |-> sck_out && !sck_oe);

endmodule

bind sync_rx srx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_done(frame_done),
    .full      (full_flag),
    .ovr       (ovr_flag),
    .ie        (ctrl.ie),
    .en        (ctrl.en),
    .ext       (ctrl.ext),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .irq_rx    (irq_rx),
    .irq_err   (irq_err),
    .sck_out   (sck_out),
    .sck_oe    (sck_oe)
);

// File: tb/sync_rx_bench.sv
module sync_rx_bench;

    localparam int CLK_P    = 10;
    localparam int HALF_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_in = 1'b1;
    logic       rxd = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic       sck_out, sck_oe;
    logic [7:0] rdata;
    logic       irq_rx, irq_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    sync_rx #(.DATA_W(8), .HALF_DIV(HALF_DIV), .SYNC_STAGES(2)) u_sync_rx (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sck_out(sck_out),
        .sck_oe(sck_oe), .rxd(rxd), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'd0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic ext_bits(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sck_in = 1'b0; rxd = b[i];
            repeat (3) @(negedge clk);
            sck_in = 1'b1;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        reg_rd(a, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic t_reset;
        expect_reg(2'd0, 8'h00, "R1 ctrl");
        expect_reg(2'd1, 8'h00, "R1 status");
        expect_reg(2'd2, 8'h00, "R1 data");
        check(!irq_rx && !irq_err, "R1 irq", {irq_rx, irq_err}, 0);
        check(sck_out && !sck_oe, "R1 sck", {sck_out, sck_oe}, 2);
    endtask

    task automatic t_regmap;
        reg_wr(2'd0, 8'hFF);
        expect_reg(2'd0, 8'h07, "R10 ctrl readback");
        reg_wr(2'd3, 8'hAA);
        reg_wr(2'd2, 8'h55);
        expect_reg(2'd3, 8'h00, "R10 addr3");
        expect_reg(2'd2, 8'h00, "R10 data not writable");
        reg_wr(2'd0, 8'h00);
        expect_reg(2'd0, 8'h00, "R10 ctrl cleared");
    endtask

    task automatic t_ext_frame;
        reg_wr(2'd0, 8'h05);
        ext_bits(8'hA3, 8);
        expect_reg(2'd2, 8'hA3, "R2 lsb-first byte");
        expect_reg(2'd1, 8'h01, "R2 full set");
        check(!irq_rx, "R11 no irq with ie=0", irq_rx, 0);
        reg_wr(2'd1, 8'h01);
        expect_reg(2'd1, 8'h00, "R2 full cleared");
    endtask

    task automatic t_overrun_and_sticky;
        reg_wr(2'd0, 8'h07);
        ext_bits(8'h3C, 8);
        check(irq_rx && !irq_err, "R3 irq_rx", {irq_rx, irq_err}, 2);
        ext_bits(8'hC5, 8);
        expect_reg(2'd1, 8'h03, "R4 overrun and full");
        expect_reg(2'd2, 8'h3C, "R4 old byte kept");
        check(!irq_rx && irq_err, "R5 irq_err replaces irq_rx", {irq_rx, irq_err}, 1);
        reg_wr(2'd1, 8'h01);
        expect_reg(2'd1, 8'h02, "R6 ovr stays after full clear");
        ext_bits(8'h99, 8);
        expect_reg(2'd1, 8'h02, "R6 frame dropped, full stays 0");
        expect_reg(2'd2, 8'h3C, "R6 data unchanged");
        check(irq_err && !irq_rx, "R6 irq_err held", {irq_rx, irq_err}, 1);
        reg_wr(2'd1, 8'h02);
        expect_reg(2'd1, 8'h00, "R6 ovr cleared");
        check(!irq_err, "R5 irq_err released", irq_err, 0);
        ext_bits(8'h5A, 8);
        expect_reg(2'd2, 8'h5A, "R6 reception resumes");
        reg_wr(2'd1, 8'h01);
    endtask

    task automatic t_back_to_back;
        logic [7:0] v;
        reg_wr(2'd0, 8'h07);
        ext_bits(8'h11, 8);
        reg_rd(2'd2, v);
        check(v == 8'h11, "R7 first byte", v, 8'h11);
        reg_wr(2'd1, 8'h01);
        ext_bits(8'hE8, 8);
        reg_rd(2'd2, v);
        check(v == 8'hE8, "R7 second byte", v, 8'hE8);
        expect_reg(2'd1, 8'h01, "R7 no overrun");
        reg_wr(2'd1, 8'h01);
    endtask

    task automatic t_no_ie_overrun;
        reg_wr(2'd0, 8'h05);
        ext_bits(8'h01, 8);
        ext_bits(8'h02, 8);
        expect_reg(2'd1, 8'h03, "R11 flags without ie");
        check(!irq_rx && !irq_err, "R11 irqs low", {irq_rx, irq_err}, 0);
        reg_wr(2'd1, 8'h03);
    endtask

    task automatic t_disable_partial;
        reg_wr(2'd0, 8'h05);
        ext_bits(8'h6D, 8);
        ext_bits(8'hFF, 3);
        reg_wr(2'd0, 8'h04);
        expect_reg(2'd2, 8'h6D, "R8 data kept");
        expect_reg(2'd1, 8'h01, "R8 full kept");
        reg_wr(2'd1, 8'h01);
        reg_wr(2'd0, 8'h05);
        ext_bits(8'h92, 8);
        expect_reg(2'd2, 8'h92, "R8 restart at bit 0");
        expect_reg(2'd1, 8'h01, "R8 no spurious overrun");
        reg_wr(2'd1, 8'h01);
    endtask

    task automatic t_internal;
        time t0, per;
        logic [7:0] b = 8'hB4;
        reg_wr(2'd0, 8'h01);
        repeat (2) @(negedge clk);
        check(sck_oe == 1'b1, "R9 sck_oe", sck_oe, 1);
        @(negedge sck_out); t0 = $time;
        @(negedge sck_out); per = ($time - t0) / CLK_P;
        check(per == 2 * HALF_DIV, "R9 period", int'(per), 2 * HALF_DIV);
        reg_wr(2'd0, 8'h00);
        repeat (HALF_DIV * 3) begin
            @(negedge clk);
            check(sck_out == 1'b1, "R9 idle high when disabled", sck_out, 1);
        end
        reg_wr(2'd0, 8'h01);
        for (int i = 0; i < 8; i++) begin
            @(negedge sck_out);
            rxd = b[i];
        end
        @(posedge sck_out);
        repeat (4) @(negedge clk);
        reg_wr(2'd0, 8'h00);
        expect_reg(2'd2, 8'hB4, "R9 internal clock byte");
        expect_reg(2'd1, 8'h01, "R9 full");
        reg_wr(2'd1, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regmap();
        t_ext_frame();
        t_overrun_and_sticky();
        t_back_to_back();
        t_no_ie_overrun();
        t_disable_partial();
        t_internal();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule